// File: doc/BRIEF.md
# Gated Dual-Clock FIFO with Combined Almost Flag

This block is one direction of a clocked bidirectional buffer. It holds 512 words of 18 bits. A producer side and a consumer side each run on their own rising-edge clock, and the two clocks may be unrelated or the same net. Each side has an active-low select and a direction input. On a selected edge the direction input says whether the side pushes a word into this buffer or pops a word out of it. A side that is deselected, or whose direction belongs to the mirrored buffer, leaves this one untouched.

Occupancy is tracked with 10-bit binary pointers. These are carried across the clock boundary as Gray code through two-flop synchronizers. The consumer side drives a single flag that is high when the buffer is nearly empty or nearly full. The two thresholds are separate. Both are captured while reset is held and default to 128. The consumer side also drives an output-enable for its data pins, which is high only while the side is selected for reading.

Top module: `gated_async_fifo`

## Requirements
- R1: Words leave in the order they were stored, bit-exact, through to 512 stored words.
- R2: A word is stored on a write-clock rising edge only when wr_cs_n is 0 and wr_dir is 1; any other combination stores nothing.
- R3: full (write domain) is 1 exactly when 512 words are held. A push while full is dropped and changes no stored word.
- R4: A word is removed on a read-clock rising edge only when rd_cs_n is 0 and rd_dir is 0. rd_data shows that word after the same edge.
- R5: A pop while empty is dropped: rd_data keeps its value and empty stays 1.
- R6: rd_oe is 1 only when rd_cs_n is 0 and rd_dir is 0, and 0 for the other three combinations.
- R7: Once the pointers have settled, near_flag is 1 when the held count N satisfies N <= X or N >= 512 - Y, and 0 otherwise.
- R8: While rst_n is 0, near_flag is 1, empty is 1 and full is 0, and both pointers return to zero.
- R9: If off_ld is 0 at the last read-clock edge of reset, both X and Y are 128, even if a previous reset loaded other values.
- R10: If off_ld is 1 at the last read-clock edge of reset, X takes ae_off and Y takes af_off. off_ld outside reset has no effect.
- R11: Correct ordering and flags hold with the write and read clocks running at unrelated rates, including pushes and pops in flight on the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock, rising edge |
| rd_clk | input | 1 | Read-side clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain through synchronizers |
| off_ld | input | 1 | Offset capture enable, honoured only while reset is held |
| ae_off | input | 9 | Near-empty threshold X to capture |
| af_off | input | 9 | Near-full threshold Y to capture |
| wr_cs_n | input | 1 | Write-side select, active low |
| wr_dir | input | 1 | Write-side direction, 1 pushes into this buffer |
| wr_data | input | 18 | Word to store |
| full | output | 1 | 512 words held (write domain) |
| rd_cs_n | input | 1 | Read-side select, active low |
| rd_dir | input | 1 | Read-side direction, 0 pops from this buffer |
| rd_data | output | 18 | Last word popped |
| rd_oe | output | 1 | Drive enable for the read-side data pins |
| empty | output | 1 | No words held (read domain) |
| near_flag | output | 1 | Combined near-empty / near-full flag (read domain) |

## Verification
A push and a pop can land in the same stretch of time while the buffer sits at its full boundary. The write side then sees full drop only after the pop's pointer crosses over. To provoke this, a fast writer streams words as long as full is low, and a slower reader pops every other read cycle. The buffer fills, and the two sides then trade the last slot back and forth. Each popped word is compared in order against the bench's own record of accepted pushes, and the bench confirms that full was seen during the stream, so no word is lost or duplicated at the boundary.

// File: rtl/fifo_pkg.sv
`timescale 1ns/1ps
package fifo_pkg;

  // Action a side performs on a selected clock edge
  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,
    ACT_PUSH = 2'd1,
    ACT_POP  = 2'd2
  } port_act_e;

  // Select is active low; direction 1 pushes into this buffer, 0 pops from it
  function automatic port_act_e decode_port(input logic cs_n, input logic dir);
    if (cs_n)     return ACT_IDLE;
    else if (dir) return ACT_PUSH;
    else          return ACT_POP;
  endfunction

endpackage

// File: rtl/fifo_rst_sync.sv
`timescale 1ns/1ps
module fifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/fifo_ptr_sync.sv
`timescale 1ns/1ps
module fifo_ptr_sync #(
  parameter int unsigned PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  logic [PW-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  // Gray to binary: each bit is the parity of itself and all higher bits
  for (genvar i = 0; i < PW; i++) begin : g_g2b
    assign bin_out[i] = ^sync_q[PW-1:i];
  end
endmodule

// File: rtl/fifo_wr_ctl.sv
`timescale 1ns/1ps
module fifo_wr_ctl #(
  parameter int unsigned AW = 9,
  localparam int unsigned PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [PW-1:0] rptr_sync,
  output logic [AW-1:0] waddr,
  output logic          wen,
  output logic [PW-1:0] wgray,
  output logic          full
);
  localparam logic [PW-1:0] DEPTH_V = PW'(1) << AW;

  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d, used;

  always_comb begin
    used    = wbin_q - rptr_sync;
    full    = (used == DEPTH_V);
    wen     = push_req && !full;
    wbin_d  = wbin_q + {{AW{1'b0}}, wen};
    wgray_d = wbin_d ^ (wbin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  assign waddr = wbin_q[AW-1:0];
  assign wgray = wgray_q;

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full) |=> $stable(wbin_q));
  p_gray_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
  p_used_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    used <= DEPTH_V);
endmodule

// File: rtl/fifo_rd_ctl.sv
`timescale 1ns/1ps
module fifo_rd_ctl #(
  parameter int unsigned AW      = 9,
  parameter int unsigned DEF_OFF = 128,
  localparam int unsigned PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop_req,
  input  logic [PW-1:0] wptr_sync,
  input  logic          off_ld,
  input  logic [AW-1:0] ae_off,
  input  logic [AW-1:0] af_off,
  output logic [AW-1:0] raddr,
  output logic          ren,
  output logic [PW-1:0] rgray,
  output logic          empty,
  output logic          near_flag
);
  localparam logic [PW-1:0] DEPTH_V = PW'(1) << AW;
  localparam logic [AW-1:0] DEF_V   = AW'(DEF_OFF);

  logic [PW-1:0] rbin_q, rbin_d, rgray_q, rgray_d, used;
  logic [AW-1:0] ae_q, af_q, ae_d, af_d;
  logic          cfg_en;

  always_comb begin
    used    = wptr_sync - rbin_q;
    empty   = (used == '0);
    ren     = pop_req && !empty;
    rbin_d  = rbin_q + {{AW{1'b0}}, ren};
    rgray_d = rbin_d ^ (rbin_d >> 1);
  end

  // Threshold capture: open only while the domain is in reset
  always_comb begin
    cfg_en = !rst_n;
    ae_d   = off_ld ? ae_off : DEF_V;
    af_d   = off_ld ? af_off : DEF_V;
  end

  always_ff @(posedge clk) begin
    if (cfg_en) begin
      ae_q <= ae_d;
      af_q <= af_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
    end
  end

  assign near_flag = !rst_n
                   || (used <= {1'b0, ae_q})
                   || (used >= (DEPTH_V - {1'b0, af_q}));
  assign raddr = rbin_q[AW-1:0];
  assign rgray = rgray_q;

  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty) |=> $stable(rbin_q));
  p_empty_near_r7: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> near_flag);
  p_offsets_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(ae_q) && $stable(af_q)));
  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    used <= DEPTH_V);
endmodule

// File: rtl/gated_async_fifo.sv
`timescale 1ns/1ps
module gated_async_fifo
  import fifo_pkg::*;
#(
  parameter int unsigned DW      = 18,
  parameter int unsigned AW      = 9,
  parameter int unsigned DEF_OFF = 128
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          off_ld,
  input  logic [AW-1:0] ae_off,
  input  logic [AW-1:0] af_off,
  input  logic          wr_cs_n,
  input  logic          wr_dir,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  input  logic          rd_cs_n,
  input  logic          rd_dir,
  output logic [DW-1:0] rd_data,
  output logic          rd_oe,
  output logic          empty,
  output logic          near_flag
);
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;

  logic          wrst_n, rrst_n;
  port_act_e     wr_act, rd_act;
  logic          push_req, pop_req;
  logic [PW-1:0] wgray, rgray, wptr_at_rd, rptr_at_wr;
  logic [AW-1:0] waddr, raddr;
  logic          wen, ren;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  fifo_rst_sync u_wrst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wrst_n));
  fifo_rst_sync u_rrst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rrst_n));

  always_comb begin
    wr_act   = decode_port(wr_cs_n, wr_dir);
    rd_act   = decode_port(rd_cs_n, rd_dir);
    push_req = (wr_act == ACT_PUSH);
    pop_req  = (rd_act == ACT_POP);
    rd_oe    = (rd_act == ACT_POP);
  end

  fifo_ptr_sync #(.PW(PW)) u_r2w (
    .clk(wr_clk), .rst_n(wrst_n), .gray_in(rgray), .bin_out(rptr_at_wr));
  fifo_ptr_sync #(.PW(PW)) u_w2r (
    .clk(rd_clk), .rst_n(rrst_n), .gray_in(wgray), .bin_out(wptr_at_rd));

  fifo_wr_ctl #(.AW(AW)) u_wctl (
    .clk(wr_clk), .rst_n(wrst_n), .push_req(push_req), .rptr_sync(rptr_at_wr),
    .waddr(waddr), .wen(wen), .wgray(wgray), .full(full));

  fifo_rd_ctl #(.AW(AW), .DEF_OFF(DEF_OFF)) u_rctl (
    .clk(rd_clk), .rst_n(rrst_n), .pop_req(pop_req), .wptr_sync(wptr_at_rd),
    .off_ld(off_ld), .ae_off(ae_off), .af_off(af_off),
    .raddr(raddr), .ren(ren), .rgray(rgray), .empty(empty),
    .near_flag(near_flag));

  always_ff @(posedge wr_clk) begin
    if (wen) mem[waddr] <= wr_data;
  end

  always_ff @(posedge rd_clk or negedge rrst_n) begin
    if (!rrst_n)  rdata_q <= '0;
    else if (ren) rdata_q <= mem[raddr];
  end

  assign rd_data = rdata_q;

  always @(negedge rd_clk) begin
    if (!rst_n) p_flag_in_reset_r8: assert (near_flag);
  end
  p_oe_gate_r6: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    rd_cs_n |-> !rd_oe);
  p_rdata_hold_r5: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    !ren |=> $stable(rd_data));
endmodule

// File: tb/sim_gated_async_fifo.sv
`timescale 1ns/1ps
module sim_gated_async_fifo;
  localparam int DEPTH = 512;

  logic        wr_clk, rd_clk, rst_n, off_ld;
  logic [8:0]  ae_off, af_off;
  logic        wr_cs_n, wr_dir, rd_cs_n, rd_dir;
  logic [17:0] wr_data, rd_data;
  logic        full, rd_oe, empty, near_flag;

  int n_cmp = 0;
  int n_bad = 0;
  int cur_x, cur_y, kseq;
  logic [17:0] mq[$];
  logic [17:0] last_rd;

  gated_async_fifo u0 (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .off_ld(off_ld),
    .ae_off(ae_off), .af_off(af_off), .wr_cs_n(wr_cs_n), .wr_dir(wr_dir),
    .wr_data(wr_data), .full(full), .rd_cs_n(rd_cs_n), .rd_dir(rd_dir),
    .rd_data(rd_data), .rd_oe(rd_oe), .empty(empty), .near_flag(near_flag));

  initial wr_clk = 1'b0;
  always #2 wr_clk = ~wr_clk;     // 250 MHz
  initial rd_clk = 1'b0;
  always #3.5 rd_clk = ~rd_clk;   // unrelated read clock

  function automatic logic [17:0] pat(input int k);
    return 18'((k * 2731 + 77) & 32'h3FFFF);
  endfunction

  function automatic logic expf(input int n);
    return (n <= cur_x) || (n >= DEPTH - cur_y);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
    repeat (3) @(negedge wr_clk);
  endtask

  task automatic do_reset(input logic ld, input logic [8:0] x, input logic [8:0] y);
    wr_cs_n = 1'b1; rd_cs_n = 1'b1; rd_dir = 1'b1; wr_dir = 1'b0;
    off_ld = ld; ae_off = x; af_off = y;
    rst_n = 1'b0;
    repeat (3) @(negedge rd_clk);
    chk("R8 near_flag in reset", near_flag, 1);
    chk("R8 empty in reset", empty, 1);
    chk("R8 full in reset", full, 0);
    @(negedge rd_clk) rst_n = 1'b1;
    repeat (6) @(negedge rd_clk);
    off_ld = 1'b0;
    cur_x = ld ? int'(x) : 128;
    cur_y = ld ? int'(y) : 128;
    mq.delete();
    last_rd = '0;
    settle();
  endtask

  task automatic push(input logic cs_n, input logic dir, input logic [17:0] d);
    @(negedge wr_clk);
    wr_cs_n = cs_n; wr_dir = dir; wr_data = d;
    @(negedge wr_clk);
    wr_cs_n = 1'b1; wr_dir = 1'b0;
    if (!cs_n && dir && mq.size() < DEPTH) mq.push_back(d);
  endtask

  task automatic pop(input logic cs_n, input logic dir);
    @(negedge rd_clk);
    rd_cs_n = cs_n; rd_dir = dir;
    @(negedge rd_clk);
    rd_cs_n = 1'b1; rd_dir = 1'b1;
    if (!cs_n && !dir && mq.size() > 0) last_rd = mq.pop_front();
  endtask

  task automatic sweep(input string tag);
    chk({tag, " R7 flag at 0"}, near_flag, expf(0));
    for (int i = 1; i <= DEPTH; i++) begin
      push(1'b0, 1'b1, pat(kseq)); kseq++;
      chk({tag, " R3 full vs count"}, full, (i == DEPTH));
      settle();
      chk({tag, " R7 flag filling"}, near_flag, expf(mq.size()));
      chk({tag, " R2 empty filling"}, empty, 0);
    end
    push(1'b0, 1'b1, 18'h2BCDE);
    chk({tag, " R3 full after dropped push"}, full, 1);
    for (int i = DEPTH - 1; i >= 0; i--) begin
      pop(1'b0, 1'b0);
      chk({tag, " R1 order"}, rd_data, last_rd);
      chk({tag, " R7 flag draining"}, near_flag, expf(mq.size()));
    end
    chk({tag, " R3 no extra word, empty"}, empty, 1);
    pop(1'b0, 1'b0);
    chk({tag, " R5 pop on empty keeps data"}, rd_data, last_rd);
    chk({tag, " R5 still empty"}, empty, 1);
    settle();
    chk({tag, " R3 full clears"}, full, 0);
  endtask

  initial begin : watchdog
    #600000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    bit saw_full;
    wr_data = '0; kseq = 0; last_rd = '0;
    do_reset(1'b0, 9'd0, 9'd0);

    // R6: output-enable for every select/direction pair
    @(negedge rd_clk); rd_cs_n = 1'b1; rd_dir = 1'b0; #1 chk("R6 oe cs high dir 0", rd_oe, 0);
    rd_dir = 1'b1; #1 chk("R6 oe cs high dir 1", rd_oe, 0);
    rd_cs_n = 1'b0; #1 chk("R6 oe cs low dir 1", rd_oe, 0);
    rd_dir = 1'b0; #1 chk("R6 oe cs low dir 0", rd_oe, 1);
    @(negedge rd_clk); rd_cs_n = 1'b1; rd_dir = 1'b1;
    chk("R5 pop while empty keeps zero", rd_data, 0);

    // R2: deselected or wrong direction stores nothing
    push(1'b1, 1'b1, 18'h11111); settle();
    chk("R2 deselected push ignored", empty, 1);
    push(1'b0, 1'b0, 18'h22222); settle();
    chk("R2 wrong direction push ignored", empty, 1);

    // R4: pop gating
    push(1'b0, 1'b1, 18'h3A5A5); settle();
    chk("R2 selected push stores", empty, 0);
    pop(1'b0, 1'b1);
    chk("R4 wrong direction pop ignored", rd_data, 0);
    pop(1'b1, 1'b0);
    chk("R4 deselected pop ignored", rd_data, 0);
    chk("R4 word still held", empty, 0);
    pop(1'b0, 1'b0);
    chk("R4 selected pop data", rd_data, 18'h3A5A5);
    chk("R4 empty after pop", empty, 1);

    // R9: default thresholds, full sweep
    sweep("R9 default");

    // R10: loaded thresholds, full sweep
    do_reset(1'b1, 9'd3, 9'd10);
    sweep("R10 loaded");
    for (int i = 0; i < 5; i++) begin push(1'b0, 1'b1, pat(kseq)); kseq++; end
    settle();
    chk("R10 flag low at 5 words", near_flag, 0);
    off_ld = 1'b1; ae_off = 9'd200; af_off = 9'd200;
    settle();
    off_ld = 1'b0;
    chk("R10 load outside reset ignored", near_flag, 0);
    for (int i = 0; i < 5; i++) pop(1'b0, 1'b0);
    chk("R1 drained after load test", rd_data, last_rd);

    // R9: reset without load returns to 128
    do_reset(1'b0, 9'd7, 9'd7);
    for (int i = 1; i <= 129; i++) begin
      push(1'b0, 1'b1, pat(kseq)); kseq++;
      if (i >= 128) begin
        settle();
        chk("R9 default restored", near_flag, expf(i));
      end
    end

    // R11 / R3: concurrent streaming through the full boundary
    do_reset(1'b0, 9'd0, 9'd0);
    saw_full = 1'b0;
    fork
      begin : writer
        int sent = 0;
        while (sent < 1500) begin
          @(negedge wr_clk);
          if (full) saw_full = 1'b1;
          if (!full) begin
            wr_cs_n = 1'b0; wr_dir = 1'b1; wr_data = pat(kseq);
            mq.push_back(pat(kseq)); kseq++; sent++;
          end else begin
            wr_cs_n = 1'b1;
          end
        end
        @(negedge wr_clk) wr_cs_n = 1'b1;
      end
      begin : reader
        int got = 0;
        while (got < 1500) begin
          @(negedge rd_clk);
          if (!empty) begin
            rd_cs_n = 1'b0; rd_dir = 1'b0;
            @(negedge rd_clk);
            rd_cs_n = 1'b1; rd_dir = 1'b1;
            chk("R11 R1 concurrent order", rd_data, mq.pop_front());
            got++;
          end
        end
      end
    join
    chk("R3 full reached while streaming", saw_full, 1);
    settle();
    chk("R11 empty after stream", empty, 1);
    chk("R11 full clear after stream", full, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule